// File: doc/BRIEF.md
# Bitstream-to-temperature back-end

This block converts the single-bit output of a first-order charge-balancing temperature modulator into a signed temperature reading. A conversion is bracketed by a start strobe and a done strobe. In between, every bit marked valid is added into a sum with a triangular (second-order sinc) weight, which rises over the first half of the conversion and falls over the second half. The weighted sum stands for the measured bitstream mean µ = S/W, where W = H·(H+1) is the total weight and H is half the conversion length.

The modulator runs with a reduced charge-balance factor α. Its mean therefore has to be mapped onto the ratio that is proportional to absolute temperature, µP = αP·µ / (α + (αP−α)·µ). The block folds the normalisation by W into this single correction, so one restoring division yields µP in Q1.23. The result is then scaled linearly to degrees Celsius with a programmable gain and offset. A programmable sixth-order polynomial, evaluated in Horner form on a single shared multiplier, removes the residual curvature.

The coefficients are plain input ports. They must be held stable from the done strobe until the result appears.

Top module: `thermo_backend`

## Requirements
- R1: While reset is low and after its release, temp_out is 0, temp_valid is 0 and overrun is 0 until a conversion completes or a bit arrives during a busy window.
- R2: After conv_start, the k-th accepted bit (k counted from 0) with value 1 adds the weight k+1 when k < H, 2H−k when H ≤ k < 2H, and 0 when k ≥ 2H, where 2H = NBITS (default 6000). A bit that is valid in the same cycle as conv_done is included. Bits with value 0 add nothing.
- R3: From the weighted sum S, the block computes q = floor(αP·S·2^23 / (α·W + (αP−α)·S)), with α = 2, αP = 18 and W = H·(H+1). This is µP in Q1.23 and ranges from 0 to 2^23.
- R4: The linear reading is x = sat(floor(A·q / 2^23) + B). A (scale_a) and B (offset_b) are signed 24-bit values in units of 1/256 °C.
- R5: The polynomial is evaluated as acc = c6, then, for k = 5 down to 0, acc = floor(acc·x / 2^15) + ck. Coefficient ck is the signed 24-bit field poly_coef[24k+23:24k], in units of 1/256 °C. The output is sat(acc).
- R6: temp_valid is a one-cycle pulse. It is high exactly 31 clock cycles after the cycle in which conv_done was accepted. temp_out changes only in a cycle where temp_valid is high and holds its value otherwise.
- R7: sat() clamps to the signed 16-bit range −32768 to 32767, i.e. ±128 °C in 1/256 °C steps. It applies both to x and to the final output.
- R8: conv_start takes priority over every other input in every state. It clears the weighted sum and the bit index, aborts any arithmetic in progress so that no temp_valid follows, and clears overrun.
- R9: A valid bit in the busy window, which runs from the cycle after conv_done to the temp_valid cycle inclusive, sets overrun from the next cycle onward. overrun stays set until reset or the next conv_start. Such a bit does not change the result.
- R10: When no conversion is open, valid bits and conv_done strobes are ignored. They produce no temp_valid and do not set overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Opens a new conversion and clears the accumulators |
| conv_done | input | 1 | Closes the open conversion and starts the arithmetic |
| bit_valid | input | 1 | Qualifies bit_in |
| bit_in | input | 1 | Modulator output bit |
| scale_a | input | 24 | Linear gain A, signed, 1/256 °C per unit ratio |
| offset_b | input | 24 | Linear offset B, signed, 1/256 °C |
| poly_coef | input | 168 | Seven signed 24-bit correction coefficients, c0 in the lowest field |
| temp_out | output | 16 | Signed temperature in 1/256 °C |
| temp_valid | output | 1 | One-cycle pulse marking a new temp_out |
| overrun | output | 1 | Sticky flag for bits arriving during arithmetic |

## Verification
The main function is exercised with several bit patterns, each of which separates a different class of fault:
- A sparse random stream with idle gaps in the valid strobe shows whether each weight follows the accepted-bit index rather than the clock count.
- A strictly periodic stream gives a smooth mid-range ratio. Run under a second gain and offset, it separates the divide from the linear scaling.
- All-zero and all-one streams drive the ratio to its two ends, 0 and exactly 1, and push the reading into both saturation limits.
- A non-trivial coefficient set distinguishes the coefficient ordering and the Horner shift from an identity polynomial.
- Conversions closed early and closed late expose the rising and the zero-weight parts of the triangle.
- Bits injected into the busy window, an abort by a new start, and strobes while no conversion is open exercise the control paths.

// File: rtl/thermo_pkg.sv
// Shared types for the bitstream-to-temperature back-end.
package thermo_pkg;
    // Controller phases: waiting, collecting bits, arithmetic in flight.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_BUSY
    } ctl_state_e;
endpackage

// File: rtl/tri_accum.sv
// Triangular-weighted bit accumulator (second-order sinc over one conversion).
// Assumes NBITS is even; bits past NBITS receive weight zero.
// sum_upd is the sum including the bit presented this cycle.
module tri_accum #(
    parameter int NBITS = 6000,
    parameter int SUM_W = 24,
    parameter int IW    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [SUM_W-1:0] sum_upd
);
    localparam int HALF = NBITS / 2;

    logic [IW-1:0]    idx;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wt;

    // Weight for the current index: rising ramp, falling ramp, then zero.
    always_comb begin
        if (idx < IW'(HALF))
            wt = SUM_W'(idx) + SUM_W'(1);
        else if (idx < IW'(NBITS))
            wt = SUM_W'(NBITS) - SUM_W'(idx);
        else
            wt = '0;
    end

    assign sum_upd = sum + ((en && bit_in) ? wt : '0);

    // Index and sum registers; index saturates at NBITS.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
            sum <= '0;
        end else if (en) begin
            sum <= sum_upd;
            if (idx < IW'(NBITS))
                idx <= idx + IW'(1);
        end
    end
endmodule

// File: rtl/restoring_div.sv
// Restoring divider producing QW quotient bits, one per clock, MSB first.
// Assumes num <= den and den != 0; quo = floor(num * 2^(QW-1) / den).
module restoring_div #(
    parameter int NW = 28,
    parameter int QW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic [QW-1:0] quo,
    output logic          fin
);
    localparam int CNT_W = $clog2(QW);

    logic [NW:0]      rem;
    logic [NW-1:0]    dsr;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic             take;
    logic [NW-1:0]    trial;

    // One restoring step: subtract when the partial remainder allows it.
    always_comb begin
        take  = rem >= {1'b0, dsr};
        trial = take ? NW'(rem - {1'b0, dsr}) : rem[NW-1:0];
    end

    // Iteration registers and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            dsr  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            quo  <= '0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (clr) begin
                busy <= 1'b0;
            end else if (load) begin
                rem  <= {1'b0, num};
                dsr  <= den;
                cnt  <= '0;
                quo  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                rem <= {trial, 1'b0};
                quo <= {quo[QW-2:0], take};
                cnt <= cnt + CNT_W'(1);
                if (cnt == CNT_W'(QW - 1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/scale_poly.sv
// Linear Celsius scaling followed by Horner evaluation of the correction
// polynomial, all on one shared signed multiplier.
// The load cycle computes x = sat(A*q >> (QW-1) + B); each of the next
// ORDER cycles performs one Horner step with x taken as a Q1.(XW-1) fraction.
// Assumes the coefficients are stable while busy.
module scale_poly #(
    parameter int QW    = 24,
    parameter int CW    = 24,
    parameter int XW    = 16,
    parameter int ORDER = 6,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    load,
    input  logic [QW-1:0]           quo,
    input  logic [CW-1:0]           scale_a,
    input  logic [CW-1:0]           offset_b,
    input  logic [(ORDER+1)*CW-1:0] coefs,
    output logic [XW-1:0]           result,
    output logic                    fin
);
    localparam int SW = $clog2(ORDER + 1);
    localparam logic signed [63:0] HI = (64'sd1 <<< (XW - 1)) - 64'sd1;
    localparam logic signed [63:0] LO = -(64'sd1 <<< (XW - 1));

    logic [CW-1:0]            coef [ORDER+1];
    logic [CW-1:0]            coef_sel;
    logic signed [ACC_W-1:0]  acc;
    logic signed [XW-1:0]     x;
    logic [SW-1:0]            cidx;
    logic                     busy;
    logic signed [63:0]       ea, eb, prod, shifted, addend, total;

    // Unpack the coefficient fields, c0 in the lowest field.
    for (genvar k = 0; k <= ORDER; k++) begin : g_coef
        assign coef[k] = coefs[k*CW +: CW];
    end

    assign coef_sel = coef[cidx];

    // Clamp to the signed XW-bit range.
    function automatic logic [XW-1:0] sat_x(input logic signed [63:0] v);
        if (v > HI)
            return HI[XW-1:0];
        else if (v < LO)
            return LO[XW-1:0];
        else
            return v[XW-1:0];
    endfunction

    // Shared multiplier operands: gain*ratio on load, acc*x while busy.
    always_comb begin
        ea      = busy ? {{(64-ACC_W){acc[ACC_W-1]}}, acc}
                       : {{(64-CW){scale_a[CW-1]}}, scale_a};
        eb      = busy ? {{(64-XW){x[XW-1]}}, x}
                       : {{(64-QW){1'b0}}, quo};
        prod    = ea * eb;
        shifted = busy ? (prod >>> (XW - 1)) : (prod >>> (QW - 1));
        addend  = busy ? {{(64-CW){coef_sel[CW-1]}}, coef_sel}
                       : {{(64-CW){offset_b[CW-1]}}, offset_b};
        total   = shifted + addend;
    end

    // Step sequencing, accumulator, reading and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            x      <= '0;
            cidx   <= '0;
            busy   <= 1'b0;
            result <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (clr) begin
                busy <= 1'b0;
            end else if (load) begin
                x    <= sat_x(total);
                acc  <= {{(ACC_W-CW){coef[ORDER][CW-1]}}, coef[ORDER]};
                cidx <= SW'(ORDER - 1);
                busy <= 1'b1;
            end else if (busy) begin
                acc  <= total[ACC_W-1:0];
                cidx <= cidx - SW'(1);
                if (cidx == '0) begin
                    busy   <= 1'b0;
                    fin    <= 1'b1;
                    result <= sat_x(total);
                end
            end
        end
    end
endmodule

// File: rtl/thermo_backend.sv
// Bitstream-to-temperature back-end: triangular decimation, ratio
// correction by division, linear Celsius scaling and polynomial trim.
// Assumes the coefficient inputs are stable from conv_done to temp_valid.
// Latency from the accepted conv_done to temp_valid is QW + ORDER + 1 cycles.
module thermo_backend
    import thermo_pkg::*;
#(
    parameter int NBITS   = 6000,
    parameter int ALPHA   = 2,
    parameter int ALPHA_P = 18,
    parameter int QW      = 24,
    parameter int CW      = 24,
    parameter int XW      = 16,
    parameter int ORDER   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv_start,
    input  logic                    conv_done,
    input  logic                    bit_valid,
    input  logic                    bit_in,
    input  logic [CW-1:0]           scale_a,
    input  logic [CW-1:0]           offset_b,
    input  logic [(ORDER+1)*CW-1:0] poly_coef,
    output logic [XW-1:0]           temp_out,
    output logic                    temp_valid,
    output logic                    overrun
);
    localparam int HALF  = NBITS / 2;
    localparam int WSUM  = HALF * (HALF + 1);
    localparam int SUM_W = $clog2(WSUM + 1);
    localparam int NW    = $clog2(ALPHA_P * WSUM + 1);
    localparam int IW    = $clog2(NBITS + 1);

    ctl_state_e       state;
    logic             accept, div_load, div_fin, busy_win;
    logic [SUM_W-1:0] sum_upd;
    logic [NW-1:0]    sum_ext, num, den;
    logic [QW-1:0]    quo;

    assign accept   = (state == ST_ACCUM) && bit_valid && !conv_start;
    assign div_load = (state == ST_ACCUM) && conv_done && !conv_start;
    assign busy_win = (state == ST_BUSY);

    // Ratio correction operands with the total weight folded in.
    assign sum_ext = {{(NW-SUM_W){1'b0}}, sum_upd};
    assign num     = sum_ext * NW'(ALPHA_P);
    assign den     = NW'(ALPHA * WSUM) + sum_ext * NW'(ALPHA_P - ALPHA);

    tri_accum #(.NBITS(NBITS), .SUM_W(SUM_W), .IW(IW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (conv_start),
        .en     (accept),
        .bit_in (bit_in),
        .sum_upd(sum_upd)
    );

    restoring_div #(.NW(NW), .QW(QW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (conv_start),
        .load (div_load),
        .num  (num),
        .den  (den),
        .quo  (quo),
        .fin  (div_fin)
    );

    scale_poly #(.QW(QW), .CW(CW), .XW(XW), .ORDER(ORDER)) u_poly (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (conv_start),
        .load    (div_fin),
        .quo     (quo),
        .scale_a (scale_a),
        .offset_b(offset_b),
        .coefs   (poly_coef),
        .result  (temp_out),
        .fin     (temp_valid)
    );

    // Conversion phase control; start wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (conv_start)
            state <= ST_ACCUM;
        else if (div_load)
            state <= ST_BUSY;
        else if (busy_win && temp_valid)
            state <= ST_IDLE;
    end

    // Sticky flag for bits arriving while the arithmetic runs.
    always_ff @(posedge clk) begin
        if (!rst_n || conv_start)
            overrun <= 1'b0;
        else if (busy_win && bit_valid)
            overrun <= 1'b1;
    end
endmodule

// File: rtl/thermo_backend_chk.sv
// Temporal checks on the back-end's control outputs, bound into the top.
module thermo_backend_chk #(
    parameter int XW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_start,
    input logic          bit_valid,
    input logic          in_busy,
    input logic          temp_valid,
    input logic          overrun,
    input logic [XW-1:0] temp_out
);
    // R6: the valid strobe lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |=> !temp_valid);

    // R6: a result only appears while a conversion is being processed
    a_r6_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid |-> in_busy);

    // R6: the reading holds between results
    a_r6_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(temp_out) |-> temp_valid);

    // R9: a bit during the busy window raises the flag
    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busy && bit_valid && !conv_start) |=> overrun);

    // R9: the flag is sticky until a new start
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !conv_start) |=> overrun);

    // R10: the flag never rises without a busy-window bit
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!overrun && !(in_busy && bit_valid)) |=> !overrun);

    // R8: start clears the flag and suppresses any pending result
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (!overrun && !temp_valid));
endmodule

bind thermo_backend thermo_backend_chk #(.XW(XW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .bit_valid (bit_valid),
    .in_busy   (busy_win),
    .temp_valid(temp_valid),
    .overrun   (overrun),
    .temp_out  (temp_out)
);

// File: tb/tb_thermo_backend.sv
`timescale 1ns/1ps
module tb_thermo_backend;
    localparam int N   = 6000;
    localparam int H   = N / 2;
    localparam int LAT = 31;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_start = 1'b0, conv_done = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
    logic [23:0]  ca, cb;
    logic [23:0]  cp [7];
    logic [167:0] poly_vec;
    logic [15:0]  temp_out;
    logic         temp_valid, overrun;

    always #2 clk = ~clk;

    always_comb for (int k = 0; k < 7; k++) poly_vec[k*24 +: 24] = cp[k];

    thermo_backend dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .bit_valid(bit_valid), .bit_in(bit_in), .scale_a(ca), .offset_b(cb),
        .poly_coef(poly_vec), .temp_out(temp_out), .temp_valid(temp_valid),
        .overrun(overrun)
    );

    int     checks = 0, fails = 0;
    longint cyc = 0;
    bit     cmp_en = 0, ended = 0;
    string  cur_tag = "R1";

    // Reference model state
    int     m_state = 0, m_idx = 0, m_cnt = 0;
    longint m_sum = 0, m_res = 0, m_pend = 0, done_cyc = 0;
    bit     m_over = 0, m_valid = 0;
    int     valid_cnt = 0;
    longint last_out = 0;

    function automatic longint sx24(logic [23:0] v);
        return longint'(signed'(v));
    endfunction

    function automatic longint sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint wgt(int i);
        if (i < H) return i + 1;
        if (i < N) return N - i;
        return 0;
    endfunction

    // Expected reading from the requirements (R3, R4, R5, R7)
    function automatic longint predict(longint s);
        longint w, num, den, q, x, acc;
        w   = longint'(H) * (H + 1);
        num = 18 * s;
        den = 2 * w + 16 * s;
        q   = (num <<< 23) / den;
        x   = sat16(((sx24(ca) * q) >>> 23) + sx24(cb));
        acc = sx24(cp[6]);
        for (int k = 5; k >= 0; k--) acc = ((acc * x) >>> 15) + sx24(cp[k]);
        return sat16(acc);
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Cycle model, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        m_valid = 0;
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_sum = 0; m_over = 0; m_res = 0; m_cnt = 0;
        end else if (conv_start) begin
            m_state = 1; m_idx = 0; m_sum = 0; m_over = 0;
        end else if (m_state == 1) begin
            if (bit_valid) begin
                if (bit_in) m_sum += wgt(m_idx);
                if (m_idx < N) m_idx++;
            end
            if (conv_done) begin
                m_pend = predict(m_sum);
                done_cyc = cyc;
                m_state = 2;
                m_cnt = LAT + 1;
            end
        end else if (m_state == 2) begin
            if (bit_valid) m_over = 1;
            m_cnt--;
            if (m_cnt == 1) begin m_valid = 1; m_res = m_pend; end
            if (m_cnt == 0) m_state = 0;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check(temp_valid == m_valid, "R6 valid strobe", temp_valid, m_valid);
            check(overrun == m_over, "R9 overrun flag", overrun, m_over);
            check(sx24({{8{temp_out[15]}}, temp_out}) == m_res, {cur_tag, " temp_out"},
                  longint'(signed'(temp_out)), m_res);
            if (temp_valid) begin
                valid_cnt++;
                last_out = longint'(signed'(temp_out));
                check(cyc - done_cyc == LAT, "R6 latency", cyc - done_cyc, LAT);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    function automatic bit pick(int pat, int i);
        case (pat)
            0: return ($urandom_range(0, 7) == 0);
            1: return 1'b0;
            2: return 1'b1;
            default: return (i % 7) == 0;
        endcase
    endfunction

    // One conversion; noisy injects bits into the busy window
    task automatic conv(int nbits, int pat, string tag, bit noisy);
        int v0;
        cur_tag = tag;
        v0 = valid_cnt;
        @(negedge clk) conv_start = 1;
        @(negedge clk) conv_start = 0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            bit_valid = 1; bit_in = pick(pat, i); conv_done = (i == nbits - 1);
            if (pat == 0 && $urandom_range(0, 3) == 0) begin
                @(negedge clk); bit_valid = 0; conv_done = 0;
            end
        end
        @(negedge clk) bit_valid = 0; conv_done = 0;
        if (noisy) begin
            repeat (8) @(negedge clk);
            bit_valid = 1; bit_in = 1;
            repeat (3) @(negedge clk);
            bit_valid = 0;
        end
        repeat (LAT + 6) @(negedge clk);
        check(valid_cnt == v0 + 1, {tag, " one result"}, valid_cnt - v0, 1);
        check(last_out == m_pend, {tag, " reading"}, last_out, m_pend);
    endtask

    initial begin
        int v0;
        ca = 24'(600 * 256);
        cb = 24'(-273 * 256);
        for (int k = 0; k < 7; k++) cp[k] = '0;
        cp[1] = 24'(32768);

        // R1: reset state
        repeat (3) @(negedge clk);
        cmp_en = 1;
        check(temp_out == 16'd0, "R1 temp_out in reset", temp_out, 0);
        check(temp_valid == 1'b0, "R1 temp_valid in reset", temp_valid, 0);
        check(overrun == 1'b0, "R1 overrun in reset", overrun, 0);
        @(negedge clk) rst_n = 1;
        repeat (3) @(negedge clk);
        check(temp_out == 16'd0 && !temp_valid && !overrun, "R1 after reset", temp_out, 0);

        // R3: sparse random stream with gaps, identity correction
        conv(N, 0, "R3", 0);
        // R2: periodic stream, then early and late close
        conv(N, 3, "R2", 0);
        conv(100, 3, "R2 early close", 0);
        conv(N + 100, 3, "R2 late close", 0);
        // R4: different gain and offset
        ca = 24'(650 * 256);
        cb = 24'(-300 * 256);
        conv(N, 3, "R4", 0);
        // R5: full coefficient set
        cp[0] = 24'(64);   cp[1] = 24'(32768 + 300); cp[2] = 24'(-2000);
        cp[3] = 24'(1500); cp[4] = 24'(-800);        cp[5] = 24'(400);
        cp[6] = 24'(-200);
        conv(N, 0, "R5", 0);
        // R7: both saturation limits with identity correction
        ca = 24'(600 * 256);
        cb = 24'(-273 * 256);
        for (int k = 0; k < 7; k++) cp[k] = '0;
        cp[1] = 24'(32768);
        conv(N, 1, "R7 low", 0);
        check(last_out == -32768, "R7 low clamp", last_out, -32768);
        conv(N, 2, "R7 high", 0);
        check(last_out == 32767, "R7 high clamp", last_out, 32767);
        // R9: bits in busy window
        conv(N, 3, "R9", 1);
        check(overrun == 1'b1, "R9 sticky", overrun, 1);

        // R8: abort by a new start during arithmetic
        cur_tag = "R8";
        v0 = valid_cnt;
        @(negedge clk) conv_start = 1;
        @(negedge clk) conv_start = 0;
        check(overrun == 1'b0, "R8 start clears overrun", overrun, 0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); bit_valid = 1; bit_in = (i % 3 == 0); conv_done = (i == 199);
        end
        @(negedge clk) bit_valid = 0; conv_done = 0;
        repeat (10) @(negedge clk);
        conv_start = 1;
        @(negedge clk) conv_start = 0;
        repeat (LAT + 6) @(negedge clk);
        check(valid_cnt == v0, "R8 aborted result suppressed", valid_cnt - v0, 0);
        conv(N, 0, "R8 after abort", 0);

        // R10: strobes while no conversion is open
        v0 = valid_cnt;
        repeat (5) begin
            @(negedge clk); bit_valid = 1; bit_in = 1; conv_done = 1;
        end
        @(negedge clk) bit_valid = 0; conv_done = 0;
        repeat (LAT + 6) @(negedge clk);
        check(valid_cnt == v0, "R10 no result from idle strobes", valid_cnt - v0, 0);
        check(overrun == 1'b0, "R10 no overrun from idle bits", overrun, 0);

        finish_up();
    end
endmodule